// File: doc/BRIEF.md
# Addressed SPI Register-Access Front End

This block is an SPI target front end for a small port-expander register file. Up to eight such devices can share one chip select. Each frame opens with a control byte. The control byte carries a fixed device-type prefix, a 3-bit device address and a direction flag. A register address byte follows it. After that come data bytes that are either written into the register bank or read back from it. The front end drives a simple internal strobe interface toward the register bank. It takes a one-cycle write pulse with address and data, and a one-cycle read pulse whose data the bank returns on the following cycle.

The SPI pins are sampled in the block's own system clock through synchronizers, so SCK must run well below the system clock. Two configuration inputs come from the bank's configuration register. The first, `addrEn`, controls whether the address field of the control byte must equal the `hwAddr` pins. The second, `seqDis`, freezes the register pointer so that every data byte of a frame targets the same register. While the pointer is free, it steps from register to register and wraps from the last register (LAST_REG, default 0x0A) back to 0x00.

Top module: `spi_addr_frontend`

## Requirements
- R1: A control byte is accepted only if bits 7:4 equal 0100 and bits 3:1 equal the expected device address. Bit 0 gives the direction: 1 is read, 0 is write. A frame whose control byte is rejected produces no register strobe and never enables MISO until chip select is released.
- R2: With `addrEn` high, the expected device address is `hwAddr`. With `addrEn` low, the expected address is 000 whatever the pins are, so control byte 0x40 (write) / 0x41 (read) is accepted and any other address field is rejected.
- R3: In a write frame, the byte after the control byte loads the register pointer. Each complete data byte after that produces exactly one single-cycle `regWr` pulse, with `regAddr` equal to the pointer and `regWrData` equal to the byte. `regWr` and `regRd` are never high together.
- R4: With `seqDis` low, the pointer advances by one after each data byte and wraps from LAST_REG to 0x00.
- R5: With `seqDis` high, the pointer never changes during the data bytes, so all write and read data bytes of the frame use the address given by the address byte.
- R6: `misoOe` stays low during the control and address bytes. It goes high after the address byte of an accepted read frame and drops once chip select is deasserted. While it is high, each data byte appears on `miso` MSB first and changes only after falling SCK edges.
- R7: In a read frame, the first data byte is the register named by the address byte. Each following byte comes from the next pointer value under R4/R5, including the wrap from LAST_REG to 0x00.
- R8: Deasserting chip select discards any partial byte without a strobe and returns the block to the control-byte phase, so the next frame is decoded from its first bit.
- R9: After reset, `regWr`, `regRd` and `misoOe` are low.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI clock, mode 0 |
| csN | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller (0 when not enabled) |
| misoOe | output | 1 | MISO pad driver enable; pad is high-impedance when low |
| hwAddr | input | 3 | Device address pins |
| addrEn | input | 1 | Require the control-byte address to match `hwAddr` |
| seqDis | input | 1 | Hold the register pointer between data bytes |
| regAddr | output | 8 | Register address for the current strobe |
| regWr | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Write data |
| regRd | output | 1 | One-cycle register read strobe |
| regRdData | input | 8 | Read data, valid the cycle after `regRd` |

## Verification
A wrong byte phase or bit count would show up at the ports within a single byte. The strobe would name the address byte as data, land at the wrong register, or not appear at all, and a read would shift its returned byte by one or more bit positions. A mismatch in address decoding shows up as a strobe or a raised `misoOe` in a frame meant for another device. A fault in pointer sequencing becomes visible on the second data byte of any frame, and wrap faults appear only in frames that start at LAST_REG. For these reasons the scenarios use multi-byte frames that start both mid-range and at the last register, and frames cut short mid-byte.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  // Fixed upper nibble of every control byte
  localparam logic [3:0] DEV_PREFIX = 4'b0100;
  localparam int HW_ADDR_W = 3;

  typedef enum logic [2:0] {
    PH_CTRL,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_IGNORE
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadTx;
    logic txEnable;
  } fe_strobe_t;

endpackage

// File: rtl/spi_fe_datapath.sv
module spi_fe_datapath
  import spi_fe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckIn,
  input  logic       csNIn,
  input  logic       mosiIn,
  input  fe_strobe_t strb,
  input  logic [7:0] rdData,
  output logic       csActive,
  output logic       byteDone,
  output logic [7:0] rxByte,
  output logic       misoOut
);

  logic [SYNC_STAGES-1:0] sckSync, csSync, mosiSync;
  logic sckS, mosiS, sckPrev;
  logic sckRise, sckFall;
  logic [2:0] bitCnt;
  logic [7:0] rxShift, txShift;

  // Input synchronizers, one chain per pin
  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sckSync  <= '0;
          csSync   <= '1;
          mosiSync <= '0;
        end else begin
          sckSync  <= sckIn;
          csSync   <= csNIn;
          mosiSync <= mosiIn;
        end
      end
    end else begin : gSyncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sckSync  <= '0;
          csSync   <= '1;
          mosiSync <= '0;
        end else begin
          sckSync  <= {sckSync[SYNC_STAGES-2:0], sckIn};
          csSync   <= {csSync[SYNC_STAGES-2:0], csNIn};
          mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosiIn};
        end
      end
    end
  endgenerate

  assign sckS     = sckSync[SYNC_STAGES-1];
  assign mosiS    = mosiSync[SYNC_STAGES-1];
  assign csActive = ~csSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sckS;
  end

  assign sckRise = csActive & sckS & ~sckPrev;
  assign sckFall = csActive & ~sckS & sckPrev;

  assign byteDone = sckRise && (bitCnt == 3'd7);
  assign rxByte   = {rxShift[6:0], mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else if (!csActive) begin
      bitCnt  <= '0;
    end else if (sckRise) begin
      bitCnt  <= bitCnt + 3'd1;
      rxShift <= {rxShift[6:0], mosiS};
    end
  end

  // Shift out only mid-byte; the falling edge after a byte boundary keeps the fresh MSB
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          txShift <= '0;
    else if (strb.loadTx)               txShift <= rdData;
    else if (sckFall && bitCnt != 3'd0) txShift <= {txShift[6:0], 1'b0};
  end

  assign misoOut = strb.txEnable ? txShift[7] : 1'b0;

  AST_BYTE_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |-> $past(csActive)) else $error("byte completed outside frame"); // R8

  AST_MISO_FALL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txEnable && $past(strb.txEnable) && !$stable(misoOut) && !$past(strb.loadTx))
      |-> $past(sckFall)) else $error("miso moved without falling edge"); // R6

endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
  import spi_fe_pkg::*;
#(
  parameter logic [7:0] LAST_REG = 8'h0A
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csActive,
  input  logic                 byteDone,
  input  logic [7:0]           rxByte,
  input  logic [HW_ADDR_W-1:0] hwAddr,
  input  logic                 addrEn,
  input  logic                 seqDis,
  output fe_strobe_t           strb,
  output logic [7:0]           regAddr,
  output logic                 regWr,
  output logic [7:0]           regWrData,
  output logic                 regRd
);

  phase_t phase;
  logic [7:0] ptr, ptrStep;
  logic [HW_ADDR_W-1:0] expectAddr;
  logic ctrlOk, txEn, loadTx;

  assign expectAddr = addrEn ? hwAddr : '0;
  assign ctrlOk  = (rxByte[7:4] == DEV_PREFIX) && (rxByte[3:1] == expectAddr);
  assign ptrStep = seqDis ? ptr : ((ptr >= LAST_REG) ? 8'h00 : ptr + 8'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_CTRL;
      ptr       <= '0;
      regAddr   <= '0;
      regWrData <= '0;
      regWr     <= 1'b0;
      regRd     <= 1'b0;
      txEn      <= 1'b0;
      loadTx    <= 1'b0;
    end else begin
      regWr  <= 1'b0;
      regRd  <= 1'b0;
      loadTx <= regRd;
      if (!csActive) begin
        phase <= PH_CTRL;
        txEn  <= 1'b0;
      end else if (byteDone) begin
        unique case (phase)
          PH_CTRL: begin
            if (!ctrlOk)        phase <= PH_IGNORE;
            else if (rxByte[0]) phase <= PH_ADDR;   // read flag kept in next decode
            else                phase <= PH_ADDR;
            txEn <= 1'b0;
            regWrData[0] <= rxByte[0];
          end
          PH_ADDR: begin
            ptr <= rxByte;
            if (regWrData[0]) begin
              phase   <= PH_RDATA;
              regAddr <= rxByte;
              regRd   <= 1'b1;
              txEn    <= 1'b1;
            end else begin
              phase <= PH_WDATA;
            end
          end
          PH_WDATA: begin
            regAddr   <= ptr;
            regWrData <= rxByte;
            regWr     <= 1'b1;
            ptr       <= ptrStep;
          end
          PH_RDATA: begin
            ptr     <= ptrStep;
            regAddr <= ptrStep;
            regRd   <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign strb.loadTx   = loadTx;
  assign strb.txEnable = txEn;

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    regWr |=> !regWr) else $error("write strobe longer than one cycle"); // R3

  AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regRd)) else $error("read and write strobes together"); // R3

  AST_OE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEn) |-> $past(phase) == PH_ADDR) else $error("miso enabled outside read start"); // R6

  AST_OE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> !txEn) else $error("miso enable held after frame end"); // R6

  AST_NO_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IGNORE && $past(phase) == PH_IGNORE) |-> !(regWr || regRd))
    else $error("strobe in rejected frame"); // R1

endmodule

// File: rtl/spi_addr_frontend.sv
module spi_addr_frontend
  import spi_fe_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] LAST_REG    = 8'h0A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sck,
  input  logic       csN,
  input  logic       mosi,
  output logic       miso,
  output logic       misoOe,
  input  logic [2:0] hwAddr,
  input  logic       addrEn,
  input  logic       seqDis,
  output logic [7:0] regAddr,
  output logic       regWr,
  output logic [7:0] regWrData,
  output logic       regRd,
  input  logic [7:0] regRdData
);

  fe_strobe_t strb;
  logic csActive, byteDone;
  logic [7:0] rxByte;

  spi_fe_datapath #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .sckIn(sck), .csNIn(csN), .mosiIn(mosi),
    .strb(strb), .rdData(regRdData), .csActive(csActive),
    .byteDone(byteDone), .rxByte(rxByte), .misoOut(miso)
  );

  spi_fe_ctrl #(.LAST_REG(LAST_REG)) uCtrl (
    .clk(clk), .rstN(rstN), .csActive(csActive), .byteDone(byteDone),
    .rxByte(rxByte), .hwAddr(hwAddr), .addrEn(addrEn), .seqDis(seqDis),
    .strb(strb), .regAddr(regAddr), .regWr(regWr), .regWrData(regWrData),
    .regRd(regRd)
  );

  assign misoOe = strb.txEnable;

endmodule

// File: tb/tb_spi_addr_frontend.sv
`timescale 1ns/1ps
module tb_spi_addr_frontend;

  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic sck = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso, misoOe;
  logic [2:0] hwAddr = 3'd5;
  logic addrEn = 1'b1, seqDis = 1'b0;
  logic [7:0] regAddr, regWrData, regRdData = 8'h00;
  logic regWr, regRd;

  int nChk = 0, nFail = 0, wrCnt = 0, rdCnt = 0;
  logic [7:0] wrA [0:63];
  logic [7:0] wrD [0:63];

  always #5 clk = ~clk;

  spi_addr_frontend dut (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi),
    .miso(miso), .misoOe(misoOe), .hwAddr(hwAddr), .addrEn(addrEn),
    .seqDis(seqDis), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRd(regRd), .regRdData(regRdData)
  );

  function automatic logic [7:0] pat(input logic [7:0] a);
    return (a * 8'h1D) ^ 8'hA6;
  endfunction

  // Register bank model: registered read
  always @(posedge clk) if (regRd) regRdData <= pat(regAddr);

  always @(negedge clk) begin
    if (regWr) begin
      wrA[wrCnt[5:0]] = regAddr;
      wrD[wrCnt[5:0]] = regWrData;
      wrCnt = wrCnt + 1;
    end
    if (regRd) rdCnt = rdCnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic halfWait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic spiBits(input logic [7:0] tx, input int nBits,
                         output logic [7:0] rx, output bit oeAny);
    rx = '0; oeAny = 0;
    for (int i = 7; i > 7 - nBits; i--) begin
      mosi = tx[i];
      halfWait();
      rx[i] = miso;
      if (misoOe) oeAny = 1;
      sck = 1'b1;
      halfWait();
      sck = 1'b0;
    end
  endtask

  task automatic frameStart();
    csN = 1'b0;
    halfWait();
  endtask

  task automatic frameEnd();
    halfWait();
    csN = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic writeFrame(input logic [7:0] ctrl, input logic [7:0] a,
                            input logic [7:0] d0, input logic [7:0] d1);
    logic [7:0] rx; bit oe;
    frameStart();
    spiBits(ctrl, 8, rx, oe);
    spiBits(a, 8, rx, oe);
    spiBits(d0, 8, rx, oe);
    spiBits(d1, 8, rx, oe);
    frameEnd();
  endtask

  task automatic testReset();
    chk(regWr == 0, "R9", "regWr after reset", regWr, 0);
    chk(regRd == 0, "R9", "regRd after reset", regRd, 0);
    chk(misoOe == 0, "R9", "misoOe after reset", misoOe, 0);
  endtask

  task automatic testWriteSeq(); // R3 R4
    int w0 = wrCnt;
    writeFrame(8'h4A, 8'h03, 8'hA5, 8'h3C);
    chk(wrCnt - w0 == 2, "R3", "write count", wrCnt - w0, 2);
    chk(wrA[w0[5:0]] == 8'h03 && wrD[w0[5:0]] == 8'hA5, "R3", "first write",
        {wrA[w0[5:0]], wrD[w0[5:0]]}, 16'h03A5);
    chk(wrA[(w0+1)%64] == 8'h04 && wrD[(w0+1)%64] == 8'h3C, "R4", "second write",
        {wrA[(w0+1)%64], wrD[(w0+1)%64]}, 16'h043C);
  endtask

  task automatic testWriteWrap(); // R4
    int w0 = wrCnt;
    writeFrame(8'h4A, 8'h0A, 8'h11, 8'h22);
    chk(wrA[w0[5:0]] == 8'h0A, "R4", "last register addr", wrA[w0[5:0]], 8'h0A);
    chk(wrA[(w0+1)%64] == 8'h00 && wrD[(w0+1)%64] == 8'h22, "R4", "wrap to 0",
        {wrA[(w0+1)%64], wrD[(w0+1)%64]}, 16'h0022);
  endtask

  task automatic testWriteHold(); // R5
    int w0 = wrCnt;
    seqDis = 1'b1;
    writeFrame(8'h4A, 8'h02, 8'h01, 8'h02);
    seqDis = 1'b0;
    chk(wrA[w0[5:0]] == 8'h02 && wrA[(w0+1)%64] == 8'h02, "R5", "held address",
        {wrA[w0[5:0]], wrA[(w0+1)%64]}, 16'h0202);
  endtask

  task automatic testMismatch(); // R1
    int w0 = wrCnt, r0 = rdCnt;
    logic [7:0] rx; bit oe, oeSeen = 0;
    writeFrame(8'h46, 8'h01, 8'h55, 8'h66);       // address 3 vs pins 5
    writeFrame(8'h5A, 8'h01, 8'h55, 8'h66);       // wrong prefix
    chk(wrCnt == w0, "R1", "writes on rejected frames", wrCnt - w0, 0);
    frameStart();
    spiBits(8'h47, 8, rx, oe); oeSeen |= oe;
    spiBits(8'h01, 8, rx, oe); oeSeen |= oe;
    spiBits(8'h00, 8, rx, oe); oeSeen |= oe;
    frameEnd();
    chk(!oeSeen && rdCnt == r0, "R1", "rejected read oe/reads", {oeSeen, 8'(rdCnt - r0)}, 0);
  endtask

  task automatic testAddrDisable(); // R2
    int w0 = wrCnt;
    addrEn = 1'b0;
    writeFrame(8'h4A, 8'h01, 8'h77, 8'h78);       // pins still 5: rejected
    chk(wrCnt == w0, "R2", "pin address ignored", wrCnt - w0, 0);
    writeFrame(8'h40, 8'h01, 8'h77, 8'h78);
    chk(wrCnt - w0 == 2 && wrA[w0[5:0]] == 8'h01 && wrD[w0[5:0]] == 8'h77, "R2",
        "address 0 accepted", wrCnt - w0, 2);
    addrEn = 1'b1;
  endtask

  task automatic readFrame(input logic [7:0] a, input int n, input string req,
                           input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2);
    logic [7:0] rx; bit oe, oeHdr = 0;
    logic [7:0] exp [3];
    exp[0] = e0; exp[1] = e1; exp[2] = e2;
    frameStart();
    spiBits(8'h4B, 8, rx, oe); oeHdr |= oe;
    spiBits(a, 8, rx, oe);     oeHdr |= oe;
    chk(!oeHdr, "R6", "oe during header", oeHdr, 0);
    for (int k = 0; k < n; k++) begin
      spiBits(8'h00, 8, rx, oe);
      chk(misoOe == 1, "R6", "oe in data", misoOe, 1);
      chk(rx == exp[k], req, "read byte", rx, exp[k]);
    end
    frameEnd();
    chk(misoOe == 0, "R6", "oe after cs high", misoOe, 0);
  endtask

  task automatic testReads();
    readFrame(8'h06, 3, "R7", pat(8'h06), pat(8'h07), pat(8'h08));
    readFrame(8'h0A, 2, "R7", pat(8'h0A), pat(8'h00), 8'h00);
    seqDis = 1'b1;
    readFrame(8'h09, 2, "R5", pat(8'h09), pat(8'h09), 8'h00);
    seqDis = 1'b0;
  endtask

  task automatic testAbort(); // R8
    int w0 = wrCnt;
    logic [7:0] rx; bit oe;
    frameStart();
    spiBits(8'h4A, 8, rx, oe);
    spiBits(8'h05, 8, rx, oe);
    spiBits(8'hFF, 5, rx, oe);
    frameEnd();
    chk(wrCnt == w0, "R8", "partial byte no write", wrCnt - w0, 0);
    frameStart();
    spiBits(8'h4A, 3, rx, oe);
    frameEnd();
    writeFrame(8'h4A, 8'h07, 8'h99, 8'h9A);
    chk(wrCnt - w0 == 2 && wrA[w0[5:0]] == 8'h07 && wrD[w0[5:0]] == 8'h99, "R8",
        "fresh frame after abort", {wrA[w0[5:0]], wrD[w0[5:0]]}, 16'h0799);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    testReset();
    testWriteSeq();
    testWriteWrap();
    testWriteHold();
    testMismatch();
    testAddrDisable();
    testReads();
    testAbort();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule